// File: doc/BRIEF.md
# Oversampled serial character receiver with error-tagged FIFO

This block turns an asynchronous serial line into parallel characters. A one-cycle enable pulse at sixteen times the bit rate sets its bit timing. The receiver looks for a falling edge on the idle-high line and checks it again in the middle of the start bit. It then samples each data bit, the optional parity bit and the first stop bit in the middle of its bit period.

Each finished character is stored in a 16-entry FIFO together with three error flags: parity error, framing error and break. The consumer sees the oldest entry on the read outputs at all times and removes it with a read-enable pulse. Character length and parity mode can be changed while the block runs, between characters. A character that arrives while the FIFO is full is dropped and raises an overrun flag.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_len` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. Data is received LSB first. The stored data byte has zeros above the character length.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. If the data bits and the parity bit do not match the selected parity, the entry's parity-error flag is set. When `cfg_par_en` is 0, no parity bit is expected and the flag stays 0.
- R3: Bit timing counts `tick16` pulses only. The first tick that sees the line low starts a candidate start bit. The line is sampled again 8 ticks later. Every later bit is sampled 16 ticks after the previous sample.
- R4: If the line is high again at the start-bit resample, the edge is discarded and no FIFO entry is produced.
- R5: If the first stop bit is sampled low, the entry's framing-error flag is set.
- R6: A break is a character in which every data bit, the parity bit (when enabled) and the stop bit are all sampled low. It stores exactly one entry with data 0x00, break flag 1, framing flag 1 and parity flag 0. No new start bit is searched for until the line has been seen high.
- R7: Entries leave the FIFO in arrival order. The oldest entry is shown on `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` whenever `fifo_empty` is 0. `fifo_count` reports the number of entries, which is at most 16. `fifo_full` is 1 at 16 entries and `fifo_empty` is 1 at 0 entries.
- R8: A character that completes while the FIFO holds 16 entries is dropped and sets `overrun`. `overrun` stays 1 until the next read that removes an entry.
- R9: A read (`rd_en` = 1) while the FIFO is empty changes nothing.
- R10: Only the first stop bit is checked. A new start bit may directly follow a single high stop bit, and extra stop time is idle line.
- R11: After reset the FIFO is empty, `fifo_count` is 0, `overrun` is 0 and the receiver waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity error flag of the oldest entry |
| rd_ferr | output | 1 | Framing error flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 16 entries |
| fifo_count | output | 5 | Number of entries held |
| overrun | output | 1 | A character was dropped because the FIFO was full |

## Verification
The bench sends a short low pulse that ends before mid-bit. A receiver without the start-bit resample would store a garbage character from it. It holds the line low far longer than a character. A receiver that restarts at once would store several break entries instead of one, and one that does not force the flags would report the wrong flags. Random characters mix every length and parity mode with deliberate parity and stop-bit errors. A wrong bit count or an inverted parity sense therefore shows up as mismatching data or flags. The bench also overfills the FIFO and reads it while empty, to catch a dropped-character or pointer error.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick16,
  input  logic                       rxd,
  input  logic [1:0]                 cfg_len,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic                       rd_perr,
  output logic                       rd_ferr,
  output logic                       rd_brk,
  output logic                       fifo_empty,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH):0]     fifo_count,
  output logic                       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] T_FULL = TW'(OSR - 1);
  localparam logic [AW:0]   C_FULL = (AW + 1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t           st;
  logic [1:0]    rx_sync;
  logic          rx_s;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          par_acc, zero_acc, perr_r;
  logic          push_v;
  logic [10:0]   push_e;
  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  wire [2:0] last_idx = 3'd4 + {1'b0, cfg_len};
  wire       brk_now  = zero_acc & ~rx_s;
  assign rx_s = rx_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      st       <= S_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      zero_acc <= 1'b0;
      perr_r   <= 1'b0;
      push_v   <= 1'b0;
      push_e   <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      push_v  <= 1'b0;
      if (tick16) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st   <= S_START;
            tcnt <= '0;
          end
          S_START: if (tcnt == T_HALF) begin
            tcnt <= '0;
            if (!rx_s) begin
              st       <= S_DATA;
              bidx     <= '0;
              shreg    <= '0;
              par_acc  <= 1'b0;
              zero_acc <= 1'b1;
              perr_r   <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          S_DATA: if (tcnt == T_FULL) begin
            tcnt        <= '0;
            shreg[bidx] <= rx_s;
            par_acc     <= par_acc ^ rx_s;
            zero_acc    <= zero_acc & ~rx_s;
            if (bidx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
            else                  bidx <= bidx + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          S_PAR: if (tcnt == T_FULL) begin
            tcnt     <= '0;
            zero_acc <= zero_acc & ~rx_s;
            perr_r   <= (par_acc ^ rx_s) != cfg_par_odd;
            st       <= S_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          S_STOP: if (tcnt == T_FULL) begin
            tcnt   <= '0;
            push_v <= 1'b1;
            push_e <= {brk_now, ~rx_s, perr_r & ~brk_now, shreg};
            st     <= brk_now ? S_BRK : S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          S_BRK: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign fifo_empty = (fifo_count == '0);
  assign fifo_full  = (fifo_count == C_FULL);
  assign do_push    = push_v & ~fifo_full;
  assign do_pop     = rd_en & ~fifo_empty;
  assign {rd_brk, rd_ferr, rd_perr, rd_data} = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_e;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      fifo_count <= '0;
      overrun    <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fifo_count <= fifo_count + 1'b1;
        2'b01:   fifo_count <= fifo_count - 1'b1;
        default: fifo_count <= fifo_count;
      endcase
      if (push_v && fifo_full) overrun <= 1'b1;
      else if (do_pop)         overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DEPTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick16,
  input logic                    rd_en,
  input logic                    fifo_empty,
  input logic                    fifo_full,
  input logic [$clog2(DEPTH):0]  fifo_count,
  input logic                    overrun,
  input logic [7:0]              rd_data,
  input logic                    rd_ferr,
  input logic                    rd_brk,
  input logic [2:0]              st
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == $past(fifo_count)) || (fifo_count == $past(fifo_count) + 1'b1) ||
    (fifo_count == $past(fifo_count) - 1'b1));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty) |=> (fifo_count <= CW'(1)));

  // R8
  overrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_full));

  // R3
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(st));

  // R6
  break_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && rd_brk) |-> (rd_data == 8'h00 && rd_ferr));
endmodule

bind serial_rx_core serial_rx_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rd_en(rd_en),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
  .overrun(overrun), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
  .st(st)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, fifo_empty, fifo_full, overrun;
  logic [4:0] fifo_count;
  logic [1:0] tdiv = 2'd0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [10:0] expq [$];

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
    .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic line(input logic v, input int ticks);
    rxd = v;
    repeat (4 * ticks) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_len(input logic [7:0] d, input int len);
    return d & 8'((1 << len) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic send(input int len, input bit pen, input bit podd, input logic [7:0] din,
                      input bit bad_par, input bit bad_stop, input int stops);
    logic [7:0] d;
    logic p;
    d = mask_len(din, len);
    if (bad_stop && d == 8'h00) d = 8'h01;
    cfg_len = 2'(len - 5); cfg_par_en = pen; cfg_par_odd = podd;
    line(1'b0, 16);
    for (int i = 0; i < len; i++) line(d[i], 16);
    if (pen) begin
      p = par_bit(d, podd) ^ bad_par;
      line(p, 16);
    end
    if (bad_stop) begin
      line(1'b0, 10);
      line(1'b1, 26);
    end else begin
      line(1'b1, 16 * stops);
    end
    expq.push_back({1'b0, bad_stop, pen & bad_par, d});
  endtask

  task automatic pop_check(input string req);
    logic [10:0] e;
    e = expq.pop_front();
    check({req, " entry present"}, {31'd0, fifo_empty}, 32'd0);
    check({req, " data"}, {24'd0, rd_data}, {24'd0, e[7:0]});
    check({req, " flags brk/ferr/perr"}, {29'd0, rd_brk, rd_ferr, rd_perr}, {29'd0, e[10:8]});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (expq.size() > 0) pop_check(req);
    check({req, " empty after drain"}, {31'd0, fifo_empty}, 32'd1);
  endtask

  initial begin
    int len;
    bit pen, podd, bp, bs;
    void'($urandom(32'h5eed_0042));
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 empty", {31'd0, fifo_empty}, 32'd1);
    check("R11 count", {27'd0, fifo_count}, 32'd0);
    check("R11 overrun", {31'd0, overrun}, 32'd0);

    // R9 read while empty
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    check("R9 count after empty read", {27'd0, fifo_count}, 32'd0);
    check("R9 overrun after empty read", {31'd0, overrun}, 32'd0);
    send(8, 0, 0, 8'hA5, 0, 0, 1);
    check("R9 one entry after empty read", {27'd0, fifo_count}, 32'd1);
    drain("R9");

    // R4 false start
    line(1'b0, 4); line(1'b1, 30);
    check("R4 no entry from glitch", {27'd0, fifo_count}, 32'd0);
    line(1'b0, 6); line(1'b1, 30);
    check("R4 no entry from short low", {27'd0, fifo_count}, 32'd0);

    // R1 each length, directed
    for (int l = 5; l <= 8; l++) send(l, 0, 0, 8'hFF, 0, 0, 1);
    drain("R1");

    // R2 parity modes, good and bad
    send(7, 1, 0, 8'h35, 0, 0, 1);
    send(7, 1, 0, 8'h35, 1, 0, 1);
    send(8, 1, 1, 8'h80, 0, 0, 2);
    send(8, 1, 1, 8'h80, 1, 0, 1);
    drain("R2");

    // R5 framing error
    send(6, 0, 0, 8'h2A, 0, 1, 1);
    send(8, 1, 0, 8'hC3, 0, 1, 1);
    drain("R5");

    // R10 back-to-back with one stop bit, then two
    send(8, 0, 0, 8'h00, 0, 0, 1);
    send(8, 0, 0, 8'hFE, 0, 0, 1);
    send(5, 1, 1, 8'h11, 0, 0, 2);
    drain("R10");

    // R6 break, long low
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    line(1'b0, 300);
    check("R6 single entry while line low", {27'd0, fifo_count}, 32'd1);
    line(1'b1, 20);
    expq.push_back({3'b110, 8'h00});
    drain("R6 even parity break");
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    line(1'b0, 250); line(1'b1, 20);
    expq.push_back({3'b110, 8'h00});
    drain("R6 odd parity break");
    send(5, 0, 0, 8'h1B, 0, 0, 1);
    drain("R6 character after break");

    // R7 R8 overrun
    for (int k = 0; k < 17; k++) send(8, 0, 0, 8'(k * 13 + 1), 0, 0, 1);
    void'(expq.pop_back());
    check("R7 full count", {27'd0, fifo_count}, 32'd16);
    check("R7 full flag", {31'd0, fifo_full}, 32'd1);
    check("R8 overrun set", {31'd0, overrun}, 32'd1);
    pop_check("R8 first after overrun");
    check("R8 overrun cleared by read", {31'd0, overrun}, 32'd0);
    check("R7 count after read", {27'd0, fifo_count}, 32'd15);
    drain("R7 order");

    // R1 R2 R5 R10 random
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 8; k++) begin
        len  = 5 + int'($urandom_range(0, 3));
        pen  = 1'($urandom_range(0, 1));
        podd = 1'($urandom_range(0, 1));
        bp   = ($urandom_range(0, 3) == 0);
        bs   = ($urandom_range(0, 5) == 0);
        send(len, pen, podd, 8'($urandom), bp, bs, 1 + int'($urandom_range(0, 1)));
      end
      drain("R1 R2 R5 R10 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_400_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule